// File: doc/BRIEF.md
# Unaligned Byte-Lane Write Packer

This block sits between a processor's sequential hub-write commands and a write FIFO that feeds a 32-bit memory. A start command loads a 19-bit byte address. After that, byte, word and long write commands arrive one at a time, and each command continues at the byte where the previous one stopped. The packer places each data byte into its byte lane of an accumulator. Each completed long is pushed into the FIFO together with its long address and a per-lane write-enable mask, so a word or long that starts at an odd byte can land anywhere, split across two longs if needed.

A transparency mode can be chosen at start time. In that mode every byte equal to 0xFF loses its write enable, and memory keeps its old content in that lane. This lets pixel data be overlaid on an existing line with holes. A flush command, or a new start command, pushes a partly filled long with only the written lanes enabled. A new start is held off until nothing is left in the accumulator and the FIFO has drained. A combined idle flag tells the surrounding logic when it may redirect the memory port.

Top module: `hub_write_packer`

## Requirements
- R1: A start command takes address bits [18:2] as the long address and bits [1:0] as the first byte lane. Every push reports its long address on `push_addr_o`.
- R2: `cmd_op_i` encodes 0 = byte (1 byte), 1 = word (2 bytes), 2 = long (4 bytes) and 3 = flush. Data bytes are taken little-endian from bit 0 of `cmd_data_i`, and consecutive commands fill consecutive byte addresses.
- R3: Lane k maps to `push_data_o[8k+7:8k]` and `push_be_o[k]`. When a command fills lane 3, the long is pushed on the cycle after acceptance and the long address then advances by one.
- R4: A command that crosses lane 3 is split: the lanes up to 3 go out in the current long, and the rest stay for the next long. For example, a long at lane 3 pushes mask 1000 followed by mask 0111, and a word at lane 1 uses mask 0110.
- R5: With transparency selected at start, any byte equal to 0xFF has its enable cleared, so memory keeps its previous value there. Without transparency, 0xFF is written like any other byte.
- R6: A flush pushes a partly filled long with only its written lanes enabled. It does not move the byte pointer, so later bytes complete the same long address in a further push.
- R7: `init_ready_o` is high only when the accumulator is empty, no push is in flight and `fifo_empty_i` is high. A start request that finds buffered bytes pushes them first. No push follows an accepted start.
- R8: `done_o` is high exactly when no byte is buffered or in flight and the FIFO is empty.
- R9: `cmd_ready_o` is low while `fifo_full_i` or `init_valid_i` is high. No push is issued for a command accepted while the FIFO was full.
- R10: After reset the packer holds no data, `push_o` is low, `done_o` is high for an empty FIFO, and the pointer is long 0, lane 0, with transparency off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_valid_i | input | 1 | Start request, held until accepted |
| init_addr_i | input | 19 | Start byte address |
| init_filter_i | input | 1 | Transparency mode for the new stream |
| init_ready_o | output | 1 | Start request accepted this cycle if valid |
| cmd_valid_i | input | 1 | Write or flush command valid |
| cmd_op_i | input | 2 | Command code (byte, word, long, flush) |
| cmd_data_i | input | 32 | Command data, byte 0 at bit 0 |
| cmd_ready_o | output | 1 | Command accepted this cycle if valid |
| fifo_full_i | input | 1 | Write FIFO cannot take more entries |
| fifo_empty_i | input | 1 | Write FIFO holds nothing |
| push_o | output | 1 | Push one entry into the write FIFO |
| push_addr_o | output | 17 | Long address of the pushed entry |
| push_data_o | output | 32 | Pushed long data |
| push_be_o | output | 4 | Per-lane write enables of the pushed entry |
| done_o | output | 1 | All writes have drained |

## Verification
A wrong byte pointer or lane offset shows up at the next push. That push carries the wrong enable mask or the wrong long address, and once the FIFO model has drained, the memory image differs at one or two byte addresses. A stale accumulator shows as an extra or missing push when the next flush or start arrives, and as `done_o` rising too early or never. Filter state kept across a start command shows up within one command as enables set on 0xFF lanes. Each scenario compares the push log and the full memory image as soon as `done_o` rises.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_WORD  = 2'd1,
    OP_LONG  = 2'd2,
    OP_FLUSH = 2'd3
  } op_e;
endpackage

// File: rtl/hwp_lane_map.sv
// Places command bytes on a double-width lane window starting at the current lane.
module hwp_lane_map
  import hwp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0]  data_i,
  input  op_e                 op_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [16*LANES-1:0] data_o,
  output logic [2*LANES-1:0]  fill_o,
  output logic [OFF_W:0]      nbytes_o
);
  logic [LANES-1:0] base;

  always_comb begin
    unique case (op_i)
      OP_BYTE: begin base = LANES'(1); nbytes_o = (OFF_W+1)'(1); end
      OP_WORD: begin base = LANES'(3); nbytes_o = (OFF_W+1)'(2); end
      OP_LONG: begin base = '1;        nbytes_o = (OFF_W+1)'(LANES); end
      default: begin base = '0;        nbytes_o = '0; end
    endcase
  end

  assign fill_o = {{LANES{1'b0}}, base} << off_i;
  assign data_o = {{8*LANES{1'b0}}, data_i} << {off_i, 3'b000};

  // R2: exactly the command's byte count is marked
  always_comb begin
    if (op_i != OP_FLUSH)
      p_fill_count_r2: assert ($countones(fill_o) == int'(nbytes_o));
  end
endmodule

// File: rtl/hwp_byte_filter.sv
// Per-lane enable: written lane, unless transparency drops a 0xFF byte.
module hwp_byte_filter #(
  parameter int N = 8
) (
  input  logic [8*N-1:0] data_i,
  input  logic [N-1:0]   fill_i,
  input  logic           filter_en_i,
  output logic [N-1:0]   en_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign en_o[k] = fill_i[k] && !(filter_en_i && (data_i[8*k +: 8] == 8'hFF));
  end

  always_comb begin
    p_en_in_fill_r5: assert ((en_o & ~fill_i) == '0);
  end
endmodule

// File: rtl/hub_write_packer.sv
module hub_write_packer
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             init_valid_i,
  input  logic [ADDR_W-1:0]                init_addr_i,
  input  logic                             init_filter_i,
  output logic                             init_ready_o,
  input  logic                             cmd_valid_i,
  input  logic [1:0]                       cmd_op_i,
  input  logic [8*LANES-1:0]               cmd_data_i,
  output logic                             cmd_ready_o,
  input  logic                             fifo_full_i,
  input  logic                             fifo_empty_i,
  output logic                             push_o,
  output logic [ADDR_W-$clog2(LANES)-1:0]  push_addr_o,
  output logic [8*LANES-1:0]               push_data_o,
  output logic [LANES-1:0]                 push_be_o,
  output logic                             done_o
);
  localparam int OFF_W   = $clog2(LANES);
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int DATA_W  = 8 * LANES;

  logic [LADDR_W-1:0] laddr_q, laddr_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [DATA_W-1:0]  acc_data_q, acc_data_d;
  logic [LANES-1:0]   acc_fill_q, acc_fill_d, acc_en_q, acc_en_d;
  logic               filter_q, filter_d;
  logic               push_d;
  logic [LADDR_W-1:0] paddr_d;
  logic [DATA_W-1:0]  pdata_d;
  logic [LANES-1:0]   pbe_d;

  op_e                op;
  logic [2*DATA_W-1:0] wide_data;
  logic [2*LANES-1:0]  wide_fill, wide_en;
  logic [OFF_W:0]      nbytes;
  logic [DATA_W-1:0]   lo_data;
  logic                acc_any, idle, cmd_fire, init_fire, init_drain, is_flush, wrap;

  assign op = op_e'(cmd_op_i);

  hwp_lane_map #(.LANES(LANES), .OFF_W(OFF_W)) u_map (
    .data_i  (cmd_data_i),
    .op_i    (op),
    .off_i   (off_q),
    .data_o  (wide_data),
    .fill_o  (wide_fill),
    .nbytes_o(nbytes)
  );

  hwp_byte_filter #(.N(2*LANES)) u_filt (
    .data_i     (wide_data),
    .fill_i     (wide_fill),
    .filter_en_i(filter_q),
    .en_o       (wide_en)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++)
      lo_data[8*k +: 8] = wide_fill[k] ? wide_data[8*k +: 8] : acc_data_q[8*k +: 8];
  end

  assign acc_any      = |acc_fill_q;
  assign idle         = !acc_any && !push_o && fifo_empty_i;
  assign init_ready_o = idle;
  assign done_o       = idle;
  assign cmd_ready_o  = !fifo_full_i && !init_valid_i;
  assign cmd_fire     = cmd_valid_i && cmd_ready_o;
  assign init_fire    = init_valid_i && idle;
  assign init_drain   = init_valid_i && acc_any && !fifo_full_i;
  assign is_flush     = (op == OP_FLUSH);
  assign wrap         = wide_fill[LANES-1];

  always_comb begin
    laddr_d    = laddr_q;
    off_d      = off_q;
    acc_data_d = acc_data_q;
    acc_fill_d = acc_fill_q;
    acc_en_d   = acc_en_q;
    filter_d   = filter_q;
    push_d     = 1'b0;
    paddr_d    = laddr_q;
    pdata_d    = acc_data_q;
    pbe_d      = acc_en_q;
    if (init_fire) begin
      laddr_d  = init_addr_i[ADDR_W-1:OFF_W];
      off_d    = init_addr_i[OFF_W-1:0];
      filter_d = init_filter_i;
    end else if (init_drain) begin
      push_d     = 1'b1;
      acc_fill_d = '0;
      acc_en_d   = '0;
    end else if (cmd_fire) begin
      if (is_flush) begin
        push_d     = acc_any;
        acc_fill_d = '0;
        acc_en_d   = '0;
      end else begin
        off_d = off_q + nbytes[OFF_W-1:0];
        if (wrap) begin
          push_d     = 1'b1;
          pdata_d    = lo_data;
          pbe_d      = acc_en_q | wide_en[LANES-1:0];
          acc_data_d = wide_data[2*DATA_W-1:DATA_W];
          acc_fill_d = wide_fill[2*LANES-1:LANES];
          acc_en_d   = wide_en[2*LANES-1:LANES];
          laddr_d    = laddr_q + 1'b1;
        end else begin
          acc_data_d = lo_data;
          acc_fill_d = acc_fill_q | wide_fill[LANES-1:0];
          acc_en_d   = acc_en_q | wide_en[LANES-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q     <= '0;
      off_q       <= '0;
      acc_data_q  <= '0;
      acc_fill_q  <= '0;
      acc_en_q    <= '0;
      filter_q    <= 1'b0;
      push_o      <= 1'b0;
      push_addr_o <= '0;
      push_data_o <= '0;
      push_be_o   <= '0;
    end else begin
      laddr_q    <= laddr_d;
      off_q      <= off_d;
      acc_data_q <= acc_data_d;
      acc_fill_q <= acc_fill_d;
      acc_en_q   <= acc_en_d;
      filter_q   <= filter_d;
      push_o     <= push_d;
      if (push_d) begin
        push_addr_o <= paddr_d;
        push_data_o <= pdata_d;
        push_be_o   <= pbe_d;
      end
    end
  end

  p_no_push_when_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(fifo_full_i));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cmd_valid_i && !init_valid_i) |=> !push_o);

  p_init_no_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_valid_i && init_ready_o) |=> !push_o);

  p_partial_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !filter_q) |-> (push_be_o != '0));

  p_full_long_top_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && !is_flush && wrap && !filter_q) |=> (push_o && push_be_o[LANES-1]));
endmodule

// File: tb/hub_write_packer_tb.sv
module hub_write_packer_tb;
  localparam time CLK_P = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_valid_i = 1'b0;
  logic [18:0] init_addr_i = '0;
  logic        init_filter_i = 1'b0;
  logic        init_ready_o;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [31:0] cmd_data_i = '0;
  logic        cmd_ready_o;
  logic        fifo_full_i, fifo_empty_i;
  logic        push_o;
  logic [16:0] push_addr_o;
  logic [31:0] push_data_o;
  logic [3:0]  push_be_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  hub_write_packer u_dut (.*);

  // FIFO and memory model
  typedef struct { logic [16:0] a; logic [31:0] d; logic [3:0] b; } ent_t;
  ent_t        fq[$];
  int          fcnt = 0;
  int          full_lvl = 8;
  logic        drain_en = 1'b1;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  int          push_count = 0;
  logic [3:0]  lg_be [64];
  logic [16:0] lg_addr [64];
  logic [31:0] lg_data [64];

  assign fifo_full_i  = (fcnt >= full_lvl);
  assign fifo_empty_i = (fcnt == 0);

  always @(posedge clk_i) begin
    int nc;
    ent_t e;
    nc = fcnt;
    if (drain_en && fq.size() > 0) begin
      e = fq.pop_front();
      for (int k = 0; k < 4; k++)
        if (e.b[k]) mem[{e.a[5:0], 2'(k)}] = e.d[8*k +: 8];
      nc--;
    end
    if (push_o) begin
      fq.push_back('{a: push_addr_o, d: push_data_o, b: push_be_o});
      lg_be[push_count % 64]   = push_be_o;
      lg_addr[push_count % 64] = push_addr_o;
      lg_data[push_count % 64] = push_data_o;
      push_count++;
      nc++;
    end
    fcnt <= nc;
  end

  // reference pointer
  logic [18:0] exp_ptr = '0;
  logic        exp_filt = 1'b0;
  logic        init_accepted = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " memory"}, {first[23:0], mem[first], 32'h0}, {first[23:0], exp_mem[first], 32'h0});
  endtask

  task automatic do_init(input logic [18:0] a, input bit filt);
    bit rdy;
    init_accepted = 1'b0;
    init_valid_i  = 1'b1;
    init_addr_i   = a;
    init_filter_i = filt;
    while (1) begin
      #1 rdy = init_ready_o;
      @(posedge clk_i);
      if (rdy) break;
      @(negedge clk_i);
    end
    exp_ptr  = a;
    exp_filt = filt;
    @(negedge clk_i);
    init_valid_i  = 1'b0;
    init_accepted = 1'b1;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] d);
    bit rdy;
    int n;
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_data_i  = d;
    while (1) begin
      #1 rdy = cmd_ready_o;
      @(posedge clk_i);
      if (rdy) break;
      @(negedge clk_i);
    end
    n = (op == 2'd0) ? 1 : (op == 2'd1) ? 2 : (op == 2'd2) ? 4 : 0;
    for (int i = 0; i < n; i++) begin
      if (!(exp_filt && d[8*i +: 8] == 8'hFF)) exp_mem[exp_ptr[7:0]] = d[8*i +: 8];
      exp_ptr = exp_ptr + 1'b1;
    end
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    repeat (2) @(negedge clk_i);
    while (!done_o && t < 1000) begin
      @(negedge clk_i);
      t++;
    end
  endtask

  task automatic t_reset();
    check(done_o === 1'b1, "R10 done after reset", done_o, 1);
    check(push_o === 1'b0 && cmd_ready_o === 1'b1 && init_ready_o === 1'b1,
          "R10 idle outputs", {push_o, cmd_ready_o, init_ready_o}, 3'b011);
    do_cmd(2'd0, 32'h0000_00E1);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check(lg_addr[(push_count-1)%64] == 17'h0 && lg_be[(push_count-1)%64] == 4'b0001,
          "R10 pointer at long 0 lane 0", {lg_addr[(push_count-1)%64], lg_be[(push_count-1)%64]}, {17'h0, 4'b0001});
    check_mem("R10");
  endtask

  task automatic t_aligned();
    int b = push_count;
    do_init(19'h40, 1'b0);
    do_cmd(2'd2, 32'h0302_0100);
    do_cmd(2'd2, 32'h0706_0504);
    do_cmd(2'd2, 32'h0B0A_0908);
    wait_done();
    check(push_count - b == 3, "R3 three full pushes", push_count - b, 3);
    check(lg_be[(b+2)%64] == 4'hF && lg_addr[(b+2)%64] == 17'h12 && lg_data[(b+2)%64] == 32'h0B0A_0908,
          "R1 R3 last long addr/be/data", {lg_addr[(b+2)%64], lg_be[(b+2)%64]}, {17'h12, 4'hF});
    check_mem("R3");
  endtask

  task automatic t_word_mid();
    int b = push_count;
    do_init(19'h81, 1'b0);
    do_cmd(2'd1, 32'h0000_BEEF);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check(lg_be[b%64] == 4'b0110 && lg_addr[b%64] == 17'h20 && lg_data[b%64][23:8] == 16'hBEEF,
          "R4 word at lane 1 middle lanes", {lg_addr[b%64], lg_be[b%64]}, {17'h20, 4'b0110});
    check_mem("R4 word");
  endtask

  task automatic t_split();
    int b = push_count;
    do_init(19'h103, 1'b0);
    do_cmd(2'd2, 32'hDDCC_BBAA);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check(push_count - b == 2, "R4 split push count", push_count - b, 2);
    check(lg_be[b%64] == 4'b1000 && lg_addr[b%64] == 17'h40 && lg_data[b%64][31:24] == 8'hAA,
          "R4 split first part", {lg_addr[b%64], lg_be[b%64]}, {17'h40, 4'b1000});
    check(lg_be[(b+1)%64] == 4'b0111 && lg_addr[(b+1)%64] == 17'h41 && lg_data[(b+1)%64][23:0] == 24'hDDCCBB,
          "R4 split second part", {lg_addr[(b+1)%64], lg_be[(b+1)%64]}, {17'h41, 4'b0111});
    check_mem("R4 split");
  endtask

  task automatic t_filter();
    int b = push_count;
    do_init(19'h200, 1'b1);
    do_cmd(2'd2, 32'h11FF_22FF);
    wait_done();
    check(lg_be[b%64] == 4'b1010, "R5 0xFF lanes disabled", lg_be[b%64], 4'b1010);
    do_init(19'h204, 1'b0);
    do_cmd(2'd2, 32'hFFFF_FFFF);
    wait_done();
    check(lg_be[(b+1)%64] == 4'hF, "R5 0xFF written without filter", lg_be[(b+1)%64], 4'hF);
    check_mem("R5");
  endtask

  task automatic t_flush_keep();
    int b = push_count;
    do_init(19'h300, 1'b0);
    do_cmd(2'd0, 32'h5A);
    do_cmd(2'd3, 32'h0);
    do_cmd(2'd0, 32'h6B);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check(lg_be[b%64] == 4'b0001 && lg_be[(b+1)%64] == 4'b0010,
          "R6 flush partial then continue", {lg_be[b%64], lg_be[(b+1)%64]}, {4'b0001, 4'b0010});
    check(lg_addr[b%64] == 17'hC0 && lg_addr[(b+1)%64] == 17'hC0,
          "R6 same long address after flush", {lg_addr[b%64], lg_addr[(b+1)%64]}, {17'hC0, 17'hC0});
    check_mem("R6");
  endtask

  task automatic t_mixed();
    do_init(19'h402, 1'b0);
    do_cmd(2'd0, 32'h01);
    do_cmd(2'd1, 32'h0302);
    do_cmd(2'd2, 32'h0706_0504);
    do_cmd(2'd0, 32'h08);
    do_cmd(2'd1, 32'h0A09);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check_mem("R2 mixed sizes");
  endtask

  task automatic t_high_addr();
    int b = push_count;
    do_init(19'h7FFFD, 1'b0);
    do_cmd(2'd0, 32'h77);
    do_cmd(2'd3, 32'h0);
    wait_done();
    check(lg_addr[b%64] == 17'h1FFFF && lg_be[b%64] == 4'b0010,
          "R1 top address bits", {lg_addr[b%64], lg_be[b%64]}, {17'h1FFFF, 4'b0010});
  endtask

  task automatic t_stall();
    full_lvl = 2;
    drain_en = 1'b0;
    do_init(19'h700, 1'b0);
    do_cmd(2'd2, 32'h4433_2211);
    do_cmd(2'd2, 32'h8877_6655);
    do_cmd(2'd2, 32'hCCBB_AA99);
    repeat (2) @(negedge clk_i);
    #1;
    check(cmd_ready_o === 1'b0, "R9 stall while full", cmd_ready_o, 0);
    drain_en = 1'b1;
    do_cmd(2'd2, 32'h1010_F0E0);
    wait_done();
    full_lvl = 8;
    check_mem("R9");
  endtask

  task automatic t_init_wait();
    int b;
    do_init(19'h500, 1'b0);
    b = push_count;
    drain_en = 1'b0;
    do_cmd(2'd0, 32'h99);
    fork
      do_init(19'h600, 1'b0);
    join_none
    repeat (4) @(negedge clk_i);
    check(push_count - b == 1 && init_accepted == 1'b0,
          "R7 start drains partial and waits", {push_count - b, init_accepted}, {32'd1, 1'b0});
    check(done_o === 1'b0, "R8 not done with FIFO busy", done_o, 0);
    drain_en = 1'b1;
    wait (init_accepted);
    @(negedge clk_i);
    check(done_o === 1'b1, "R8 done after drain", done_o, 1);
    check(lg_be[b%64] == 4'b0001 && lg_addr[b%64] == 17'h140,
          "R7 partial pushed", {lg_addr[b%64], lg_be[b%64]}, {17'h140, 4'b0001});
    check_mem("R7");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'h3C;
      exp_mem[i] = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_aligned();
    t_word_mid();
    t_split();
    t_filter();
    t_flush_keep();
    t_mixed();
    t_high_addr();
    t_stall();
    t_init_wait();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule